// File: doc/BRIEF.md
# Glitch-Free Card Clock Generator

This block drives the clock pin of a smart card. It takes two free-running clocks: a fast crystal clock and a slower internal oscillator clock. Software writes a 3-bit rate code, a stop bit, a park-level bit and a synchronous-mode bit through a one-cycle write port in the crystal domain. From these the block chooses the source and the division ratio. Changing rate, stopping the clock and restarting it never produce a runt pulse on the pin. A stopped clock is parked at the level that software chose.

A move from the crystal to the internal oscillator, or back, crosses clock domains. It therefore takes effect some cycles after the write. A status bit toggles at the moment the new source starts to drive the pin, so software can tell when the switch is complete. In synchronous-card mode the pin stops following a clock and simply copies a register bit.

Top module: `ccg_card_clk`

## Requirements
- R1: After reset the rate code is 000, the clock runs, the park level is low, the mode is asynchronous and `src_flag` is 0. The pin carries the crystal clock undivided: high 10 ns and low 10 ns with a 20 ns crystal period.
- R2: Rate codes 001, 010 and 011 divide the crystal clock by 2, 4 and 8. Each divided rate has equal high and low phases of 1, 2 and 4 crystal periods.
- R3: A rate code with bit 2 set selects the internal clock divided by 2, with equal phases of one internal period. Codes 101, 110 and 111 behave the same as 100.
- R4: While `wr_stop` is 1 in asynchronous mode, the pin settles at the level held by `wr_level` (0 low, 1 high) and makes no edges. A level change written while stopped moves the parked pin to the new level.
- R5: Clearing the stop bit resumes the clock at the rate selected by the rate code written with it.
- R6: During any rate change, source change, stop or restart, no phase on the pin is shorter than the shorter half period of the old and new rates. The two sources never drive the pin at the same time.
- R7: `src_flag` toggles once when a crystal/internal source change takes effect. This happens several cycles after the write and never on the write edge itself. A divisor change within the crystal source, a stop, or a restart on the same source leaves it unchanged.
- R8: With `wr_sync` written as 1, the pin equals `wr_sync_bit` from the crystal edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock; also clocks the write port |
| clk_int | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Write strobe; loads all fields below on a crystal rising edge |
| wr_rate | input | 3 | Rate code: bit 2 selects the internal source, bits 1:0 the crystal divisor |
| wr_stop | input | 1 | 1 stops the clock in asynchronous mode |
| wr_level | input | 1 | Parked level while stopped |
| wr_sync | input | 1 | 1 selects synchronous-card mode |
| wr_sync_bit | input | 1 | Pin value in synchronous-card mode |
| card_clk | output | 1 | Card clock pin |
| src_flag | output | 1 | Toggles when a source change takes effect |

## Verification
The assertions assume that the write port changes only away from crystal rising edges. They also assume that both clocks keep running, so that every handshake between the domains completes. The bench drives all writes on falling crystal edges and keeps both clocks running for the whole run. It leaves enough time after each write for the cross-domain handshake to settle before it measures the pin.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  // Width of the crystal divisor code (rate bits 1:0).
  localparam int CCG_SEL_W    = 2;
  // Largest half period, in crystal cycles, that the divisor code can ask for.
  localparam int CCG_MAX_HALF = 1 << ((1 << CCG_SEL_W) - 2);
  localparam int CCG_CNT_W    = $clog2(CCG_MAX_HALF) + 1;
  localparam int CCG_RATE_W   = CCG_SEL_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,    // no source drives the pin; park register owns it
    ST_RUN_X,   // crystal path running
    ST_STOP_X,  // crystal path finishing its phase
    ST_WAIT_I,  // internal path requested, waiting for its acknowledge
    ST_RUN_I,   // internal path running
    ST_STOP_I   // internal path finishing its phase
  } ccg_state_e;

  // Half period in crystal cycles for a divisor code; 0 means bypass.
  function automatic logic [CCG_CNT_W-1:0] half_count(input logic [CCG_SEL_W-1:0] code);
    logic [CCG_CNT_W-1:0] h;
    if (code == '0) h = '0;
    else            h = CCG_CNT_W'(1) << (code - 1'b1);
    return h;
  endfunction

  // Rate code selects the internal source when its top bit is set.
  function automatic logic rate_is_int(input logic [CCG_RATE_W-1:0] rate);
    return rate[CCG_RATE_W-1];
  endfunction
endpackage

// File: rtl/ccg_sync.sv
module ccg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ccg_xtal_div.sv
module ccg_xtal_div
  import ccg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [CCG_SEL_W-1:0] sel,
  output logic                 clk_out,
  output logic                 idle
);
  logic [CCG_CNT_W-1:0] cnt;
  logic [CCG_CNT_W-1:0] half;
  logic                 div_q;
  logic                 en_bypass;
  logic                 bypass;
  logic                 phase_end;

  assign half      = half_count(sel);
  assign bypass    = (half == '0);
  assign phase_end = (cnt == half - 1'b1);

  // Divided path: a phase always runs its full count; a stop request
  // only holds the low phase, so the last high phase is never cut.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      cnt   <= '0;
    end else if (bypass) begin
      div_q <= 1'b0;
      cnt   <= '0;
    end else if (div_q) begin
      if (phase_end) begin
        div_q <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (!run) begin
      cnt <= '0;
    end else if (phase_end) begin
      div_q <= 1'b1;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Bypass gate changes only while the crystal clock is low.
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) en_bypass <= 1'b0;
    else        en_bypass <= run && bypass;

  assign clk_out = div_q | (clk & en_bypass);
  assign idle    = !div_q && !en_bypass;
endmodule

// File: rtl/ccg_int_div.sv
module ccg_int_div #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic clk_out,
  output logic ack
);
  logic req_s;
  logic q;

  ccg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req),
    .q    (req_s)
  );

  // Toggle while requested; on release finish a high phase, then hold low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      ack <= 1'b0;
    end else begin
      q   <= req_s ? ~q : 1'b0;
      ack <= req_s | q;
    end
  end

  assign clk_out = q;
endmodule

// File: rtl/ccg_ctrl.sv
module ccg_ctrl
  import ccg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CCG_RATE_W-1:0] wr_rate,
  input  logic                  wr_stop,
  input  logic                  wr_level,
  input  logic                  wr_sync,
  input  logic                  wr_sync_bit,
  input  logic                  x_idle,
  input  logic                  i_ack_s,
  output logic                  cfg_stop,
  output logic                  cfg_level,
  output logic                  cfg_sync,
  output logic                  cfg_sync_bit,
  output logic                  x_run,
  output logic [CCG_SEL_W-1:0]  act_sel,
  output logic                  i_req,
  output logic                  park_q,
  output logic                  src_flag,
  output ccg_state_e            state
);
  logic [CCG_RATE_W-1:0] cfg_rate;
  logic                  last_int;
  logic                  want_int;
  logic                  want_x_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rate     <= '0;
      cfg_stop     <= 1'b0;
      cfg_level    <= 1'b0;
      cfg_sync     <= 1'b0;
      cfg_sync_bit <= 1'b0;
    end else if (wr_en) begin
      cfg_rate     <= wr_rate;
      cfg_stop     <= wr_stop;
      cfg_level    <= wr_level;
      cfg_sync     <= wr_sync;
      cfg_sync_bit <= wr_sync_bit;
    end
  end

  assign want_int      = rate_is_int(cfg_rate);
  assign want_x_change = cfg_stop || want_int || (cfg_rate[CCG_SEL_W-1:0] != act_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      x_run    <= 1'b0;
      act_sel  <= '0;
      i_req    <= 1'b0;
      park_q   <= 1'b0;
      src_flag <= 1'b0;
      last_int <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cfg_stop) begin
            park_q <= cfg_level;
          end else if (park_q) begin
            park_q <= 1'b0;
          end else if (want_int) begin
            i_req <= 1'b1;
            state <= ST_WAIT_I;
          end else begin
            x_run   <= 1'b1;
            act_sel <= cfg_rate[CCG_SEL_W-1:0];
            state   <= ST_RUN_X;
            if (last_int) begin
              src_flag <= ~src_flag;
              last_int <= 1'b0;
            end
          end
        end
        ST_RUN_X: begin
          if (want_x_change) begin
            x_run <= 1'b0;
            state <= ST_STOP_X;
          end
        end
        ST_STOP_X: begin
          if (x_idle) state <= ST_IDLE;
        end
        ST_WAIT_I: begin
          if (i_ack_s) begin
            state <= ST_RUN_I;
            if (!last_int) begin
              src_flag <= ~src_flag;
              last_int <= 1'b1;
            end
          end
        end
        ST_RUN_I: begin
          if (cfg_stop || !want_int) begin
            i_req <= 1'b0;
            state <= ST_STOP_I;
          end
        end
        ST_STOP_I: begin
          if (!i_ack_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccg_card_clk.sv
module ccg_card_clk
  import ccg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_xtal,
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_rate,
  input  logic       wr_stop,
  input  logic       wr_level,
  input  logic       wr_sync,
  input  logic       wr_sync_bit,
  output logic       card_clk,
  output logic       src_flag
);
  logic                 cfg_stop;
  logic                 cfg_level;
  logic                 cfg_sync;
  logic                 cfg_sync_bit;
  logic                 x_run;
  logic [CCG_SEL_W-1:0] act_sel;
  logic                 i_req;
  logic                 park_q;
  ccg_state_e           state;
  logic                 x_clk;
  logic                 x_idle;
  logic                 i_clk;
  logic                 i_ack;
  logic                 i_ack_s;

  ccg_ctrl u_ctrl (
    .clk         (clk_xtal),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_rate     (wr_rate),
    .wr_stop     (wr_stop),
    .wr_level    (wr_level),
    .wr_sync     (wr_sync),
    .wr_sync_bit (wr_sync_bit),
    .x_idle      (x_idle),
    .i_ack_s     (i_ack_s),
    .cfg_stop    (cfg_stop),
    .cfg_level   (cfg_level),
    .cfg_sync    (cfg_sync),
    .cfg_sync_bit(cfg_sync_bit),
    .x_run       (x_run),
    .act_sel     (act_sel),
    .i_req       (i_req),
    .park_q      (park_q),
    .src_flag    (src_flag),
    .state       (state)
  );

  ccg_xtal_div u_xdiv (
    .clk    (clk_xtal),
    .rst_n  (rst_n),
    .run    (x_run),
    .sel    (act_sel),
    .clk_out(x_clk),
    .idle   (x_idle)
  );

  ccg_int_div #(.SYNC_STAGES(SYNC_STAGES)) u_idiv (
    .clk    (clk_int),
    .rst_n  (rst_n),
    .req    (i_req),
    .clk_out(i_clk),
    .ack    (i_ack)
  );

  ccg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk_xtal),
    .rst_n(rst_n),
    .d    (i_ack),
    .q    (i_ack_s)
  );

  // At most one contributor is non-zero outside a handover, and each
  // one rests low before another is allowed to start.
  assign card_clk = cfg_sync ? cfg_sync_bit : (park_q | x_clk | i_clk);
endmodule

// File: rtl/ccg_card_clk_chk.sv
module ccg_card_clk_chk
  import ccg_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input ccg_state_e           state,
  input logic                 cfg_stop,
  input logic                 cfg_level,
  input logic                 park_q,
  input logic                 x_run,
  input logic                 x_idle,
  input logic                 i_req,
  input logic                 i_ack_s,
  input logic [CCG_SEL_W-1:0] act_sel,
  input logic                 src_flag
);
  // R4
  park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cfg_stop) |=> (park_q == $past(cfg_level)));

  // R6
  single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_run && i_req));

  // R6
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(park_q) |-> ($past(state) == ST_IDLE && $past(x_idle) && !$past(i_ack_s)));

  // R6
  xtal_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP_X && !x_idle) |=> (state == ST_STOP_X));

  // R7
  flag_moment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_flag) |-> ($past(state) == ST_WAIT_I || $past(state) == ST_IDLE));

  // R2
  divisor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RUN_X && state == ST_RUN_X) |-> $stable(act_sel));
endmodule

bind ccg_card_clk ccg_card_clk_chk u_chk (
  .clk     (clk_xtal),
  .rst_n   (rst_n),
  .state   (state),
  .cfg_stop(cfg_stop),
  .cfg_level(cfg_level),
  .park_q  (park_q),
  .x_run   (x_run),
  .x_idle  (x_idle),
  .i_req   (i_req),
  .i_ack_s (i_ack_s),
  .act_sel (act_sel),
  .src_flag(src_flag)
);

// File: tb/ccg_card_clk_tb.sv
`timescale 1ns/1ps
module ccg_card_clk_tb;
  localparam int XH = 10;  // crystal half period, ns (50 MHz)
  localparam int IH = 17;  // internal oscillator half period, ns

  logic       clk_xtal = 1'b0;
  logic       clk_int  = 1'b0;
  logic       rst_n    = 1'b0;
  logic       wr_en    = 1'b0;
  logic [2:0] wr_rate  = 3'b000;
  logic       wr_stop  = 1'b0;
  logic       wr_level = 1'b0;
  logic       wr_sync  = 1'b0;
  logic       wr_sync_bit = 1'b0;
  logic       card_clk;
  logic       src_flag;

  always #(XH) clk_xtal = ~clk_xtal;
  always #(IH) clk_int  = ~clk_int;

  ccg_card_clk u_dut (
    .clk_xtal   (clk_xtal),
    .clk_int    (clk_int),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_rate    (wr_rate),
    .wr_stop    (wr_stop),
    .wr_level   (wr_level),
    .wr_sync    (wr_sync),
    .wr_sync_bit(wr_sync_bit),
    .card_clk   (card_clk),
    .src_flag   (src_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct { int half; string req; } exp_t;
  exp_t exp_q[$];

  // Phase-width monitor: owns min_phase; driver restarts it via min_gen.
  int  min_gen = 0;
  int  seen_gen = 0;
  time last_t = 0;
  int  min_phase = 1000000;
  int  edge_n = 0;

  always @(card_clk) begin
    int w;
    w = int'($time - last_t);
    last_t = $time;
    edge_n++;
    if (seen_gen != min_gen) begin
      seen_gen  = min_gen;
      min_phase = w;
    end else if (w < min_phase) begin
      min_phase = w;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard monitor: measures one full period per expected item.
  initial begin
    forever begin
      exp_t it;
      time t0, t1, t2;
      wait (exp_q.size() > 0);
      it = exp_q[0];
      @(posedge card_clk); t0 = $time;
      @(negedge card_clk); t1 = $time;
      @(posedge card_clk); t2 = $time;
      check(int'(t1 - t0) == it.half, {it.req, " high phase"}, int'(t1 - t0), it.half);
      check(int'(t2 - t1) == it.half, {it.req, " low phase"},  int'(t2 - t1), it.half);
      void'(exp_q.pop_front());
    end
  end

  task automatic expect_half(input int half, input string req);
    exp_t it;
    it.half = half;
    it.req  = req;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic wr(input logic [2:0] rate, input logic stop, input logic lvl,
                    input logic sm, input logic sb);
    @(negedge clk_xtal);
    wr_en = 1'b1; wr_rate = rate; wr_stop = stop; wr_level = lvl;
    wr_sync = sm; wr_sync_bit = sb;
    @(negedge clk_xtal);
    wr_en = 1'b0;
  endtask

  task automatic min_check(input int floor_ns, input string req);
    check(min_phase >= floor_ns, req, min_phase, floor_ns);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int e0;
    #(5 * XH);
    // R1 reset state
    check(card_clk == 1'b0, "R1 pin low in reset", card_clk, 0);
    check(src_flag == 1'b0, "R1 flag clear in reset", src_flag, 0);
    @(negedge clk_xtal); rst_n = 1'b1;
    #(200);
    check(src_flag == 1'b0, "R1 flag after reset", src_flag, 0);
    expect_half(XH, "R1 undivided rate");

    // R2 divided rates, R6 no runt phases on each change
    min_gen++;
    wr(3'b001, 0, 0, 0, 0);
    #(300);
    expect_half(2 * XH, "R2 div2");
    min_check(XH, "R6 div1->div2 min phase");
    min_gen++;
    wr(3'b010, 0, 0, 0, 0);
    #(300);
    expect_half(4 * XH, "R2 div4");
    min_check(2 * XH, "R6 div2->div4 min phase");
    min_gen++;
    wr(3'b011, 0, 0, 0, 0);
    #(400);
    expect_half(8 * XH, "R2 div8");
    min_check(4 * XH, "R6 div4->div8 min phase");
    check(src_flag == 1'b0, "R7 flag kept on divisor change", src_flag, 0);

    // R3 internal source, R7 delayed status toggle
    min_gen++;
    wr(3'b111, 0, 0, 0, 0);
    check(src_flag == 1'b0, "R7 flag not yet toggled on write", src_flag, 0);
    @(negedge clk_xtal);
    check(src_flag == 1'b0, "R7 flag lags write", src_flag, 0);
    #(600);
    check(src_flag == 1'b1, "R7 flag toggled to internal", src_flag, 1);
    expect_half(2 * IH, "R3 code 111 internal div2");
    min_check(2 * IH, "R6 crystal->internal min phase");
    wr(3'b100, 0, 0, 0, 0);
    #(200);
    expect_half(2 * IH, "R3 code 100 internal div2");
    wr(3'b101, 0, 0, 0, 0);
    #(200);
    expect_half(2 * IH, "R3 code 101 internal div2");
    check(src_flag == 1'b1, "R7 flag kept within internal", src_flag, 1);

    // R4 park high, then low, with no edges
    wr(3'b101, 1, 1, 0, 0);
    #(500);
    check(card_clk == 1'b1, "R4 parked high", card_clk, 1);
    e0 = edge_n;
    #(300);
    check(edge_n == e0, "R4 no edges while parked high", edge_n - e0, 0);
    check(src_flag == 1'b1, "R7 flag kept on stop", src_flag, 1);
    wr(3'b101, 1, 0, 0, 0);
    #(200);
    check(card_clk == 1'b0, "R4 parked low", card_clk, 0);
    e0 = edge_n;
    #(300);
    check(edge_n == e0, "R4 no edges while parked low", edge_n - e0, 0);

    // R5 restart on a crystal rate from a high park
    wr(3'b101, 1, 1, 0, 0);
    #(200);
    min_gen++;
    wr(3'b001, 0, 1, 0, 0);
    #(400);
    expect_half(2 * XH, "R5 restart at div2");
    min_check(2 * XH, "R6 restart min phase");
    check(src_flag == 1'b0, "R7 flag toggled back to crystal", src_flag, 0);

    // R8 synchronous-card mode
    wr(3'b001, 0, 0, 1, 1);
    check(card_clk == 1'b1, "R8 pin copies bit 1", card_clk, 1);
    wr(3'b001, 0, 0, 1, 0);
    check(card_clk == 1'b0, "R8 pin copies bit 0", card_clk, 0);
    wr(3'b001, 0, 0, 1, 1);
    check(card_clk == 1'b1, "R8 pin copies bit 1 again", card_clk, 1);

    // R5 back to asynchronous undivided crystal
    wr(3'b000, 0, 0, 0, 0);
    #(300);
    expect_half(XH, "R5 resume undivided");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule